// File: doc/BRIEF.md
# Watchdog Timer with Paired Clear

This block is a watchdog counter. It counts ticks from one of three clock sources, and it pulls a system reset if software does not clear it within 2^CNT_W ticks. Two static configuration inputs set it up. The first picks the tick source: the system clock divided by SYS_DIV, a real-time oscillator, or a dedicated watchdog oscillator. The second picks the clear method: either one clear strobe is enough, or two different strobes must both arrive, in either order. The oscillators are modelled as one-cycle tick enables that are synchronous to `clk`. While the chip is halted, only the two oscillator sources keep advancing the count.

A timeout drives `bite_rst` high for exactly PULSE_LEN system clocks and sets the sticky `timed_out` flag. After the pulse the count starts again from zero. The flag survives the watchdog reset. It is cleared only by power-on reset (`rst_n`) or by an accepted clear.

The main FSM has two states. In `ST_COUNT` it counts. It goes to `ST_BITE` when a tick arrives while the count is at its top value. It returns to `ST_COUNT` after PULSE_LEN cycles. The clear-pair FSM has three states: `PAIR_IDLE`, `PAIR_HAVE_A` and `PAIR_HAVE_B`. Strobe A moves it from idle to have-A, and strobe B moves it from idle to have-B. It returns to idle, producing an accept, when the missing strobe arrives. It also returns to idle when both strobes arrive in one cycle. A watchdog reset flushes it back to idle, and so does single-strobe mode.

Top module: `guard_timer`

## Requirements
- R1: `cfg_src` picks the tick source. The value 0 gives one tick every SYS_DIV clocks. The value 1 uses `rtc_tick`. The values 2 and 3 use `osc_tick`. Ticks on a source that is not selected have no effect.
- R2: From a zero count, the 2^CNT_W-th selected tick drives `bite_rst` high after that clock edge, with no earlier assertion.
- R3: While `halt` is 1, source 0 stops counting. Sources 1 and 2 keep counting.
- R4: `bite_rst` stays high for exactly PULSE_LEN clocks. Ticks during the pulse are ignored. Afterwards a full 2^CNT_W ticks are needed again.
- R5: `timed_out` goes to 1 together with `bite_rst` and stays 1 after the pulse ends.
- R6: While `rst_n` is 0, `bite_rst` and `timed_out` are both 0.
- R7: With `cfg_dual`=0, a `clr_one` strobe zeroes the count, and `clr_a` and `clr_b` have no effect.
- R8: With `cfg_dual`=1, the count is zeroed only once both `clr_a` and `clr_b` have been seen, in either order or in the same cycle. `clr_one` has no effect in this mode.
- R9: After an accepted pair, both pending strobes are forgotten, so a repeated `clr_a` does not complete a pair.
- R10: A clear accepted in the same cycle as a tick wins, and the count becomes zero.
- R11: An accepted clear drops `timed_out` to 0. A single half of a pair leaves it at 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous power-on reset, active low |
| cfg_src | input | 2 | Tick source: 0 divided clock, 1 real-time osc, 2/3 watchdog osc |
| cfg_dual | input | 1 | 1 selects the two-strobe clear |
| halt | input | 1 | Chip halted; freezes the divided-clock source |
| rtc_tick | input | 1 | One-cycle tick from the real-time oscillator |
| osc_tick | input | 1 | One-cycle tick from the watchdog oscillator |
| clr_one | input | 1 | Single clear strobe |
| clr_a | input | 1 | First strobe of the paired clear |
| clr_b | input | 1 | Second strobe of the paired clear |
| bite_rst | output | 1 | System reset pulse |
| timed_out | output | 1 | Sticky time-out status |

## Verification
The bench sweeps every source, clear mode and halt setting, and it measures the time to timeout in ticks. A divider or terminal-count error would shift that number. A halt gate applied to the wrong source would either freeze an oscillator or let the divided clock run on. A pulse counter that is off by one would show up in the width measurement and in the length of the period that follows. The pairing tests try both orders, a simultaneous pair, a repeated half, and the wrong-mode strobes. A design that forgot its pending flags, or that accepted a single strobe in dual mode, would restart the count early and miss the expected timeout.

// File: rtl/guard_pkg.sv
package guard_pkg;

    typedef enum logic [1:0] {
        SRC_SYSDIV    = 2'd0,
        SRC_RTC       = 2'd1,
        SRC_LOCAL     = 2'd2,
        SRC_LOCAL_ALT = 2'd3
    } src_e;

    typedef enum logic {
        ST_COUNT = 1'b0,
        ST_BITE  = 1'b1
    } wdg_state_e;

    typedef enum logic [1:0] {
        PAIR_IDLE   = 2'd0,
        PAIR_HAVE_A = 2'd1,
        PAIR_HAVE_B = 2'd2
    } pair_state_e;

endpackage

// File: rtl/guard_tick_sel.sv
module guard_tick_sel
    import guard_pkg::*;
#(
    parameter int SYS_DIV = 4
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic [1:0] cfg_src,
    input  logic       halt,
    input  logic       rtc_tick,
    input  logic       osc_tick,
    output logic       tick
);
    localparam int DW = (SYS_DIV > 2) ? $clog2(SYS_DIV) : 1;
    localparam logic [DW-1:0] DIV_LAST = DW'(SYS_DIV - 1);

    logic [DW-1:0] div_q;
    logic          sys_tick;
    src_e          src_sel;

    assign src_sel = src_e'(cfg_src);

    // prescaler freezes while halted: the system clock is stopped then
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            div_q <= '0;
        end else if (!halt) begin
            if (div_q == DIV_LAST) begin
                div_q <= '0;
            end else begin
                div_q <= div_q + DW'(1);
            end
        end
    end

    assign sys_tick = !halt && (div_q == DIV_LAST);

    always_comb begin
        unique case (src_sel)
            SRC_SYSDIV:               tick = sys_tick;
            SRC_RTC:                  tick = rtc_tick;
            SRC_LOCAL, SRC_LOCAL_ALT: tick = osc_tick;
        endcase
    end

endmodule

// File: rtl/guard_clear_pair.sv
module guard_clear_pair
    import guard_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic dual,
    input  logic flush,
    input  logic clr_one,
    input  logic clr_a,
    input  logic clr_b,
    output logic accept
);
    pair_state_e pair_q, pair_nx;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pair_q <= PAIR_IDLE;
        end else begin
            pair_q <= pair_nx;
        end
    end

    always_comb begin
        pair_nx = pair_q;
        if (flush || !dual) begin
            pair_nx = PAIR_IDLE;
        end else begin
            unique case (pair_q)
                PAIR_IDLE: begin
                    if (clr_a && !clr_b) begin
                        pair_nx = PAIR_HAVE_A;
                    end else if (clr_b && !clr_a) begin
                        pair_nx = PAIR_HAVE_B;
                    end
                end
                PAIR_HAVE_A: if (clr_b) pair_nx = PAIR_IDLE;
                PAIR_HAVE_B: if (clr_a) pair_nx = PAIR_IDLE;
                default:     pair_nx = PAIR_IDLE;
            endcase
        end
    end

    always_comb begin
        accept = 1'b0;
        if (!flush) begin
            if (!dual) begin
                accept = clr_one;
            end else begin
                unique case (pair_q)
                    PAIR_IDLE:   accept = clr_a && clr_b;
                    PAIR_HAVE_A: accept = clr_b;
                    PAIR_HAVE_B: accept = clr_a;
                    default:     accept = 1'b0;
                endcase
            end
        end
    end

endmodule

// File: rtl/guard_core.sv
module guard_core
    import guard_pkg::*;
#(
    parameter int CNT_W     = 4,
    parameter int PULSE_LEN = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic tick,
    input  logic accept,
    output logic bite,
    output logic to_flag,
    output logic flush
);
    localparam int PW = $clog2(PULSE_LEN) + 1;
    localparam logic [CNT_W-1:0] CNT_TOP = '1;
    localparam logic [PW-1:0]    P_LAST  = PW'(PULSE_LEN - 1);

    wdg_state_e       state_q, state_nx;
    logic [CNT_W-1:0] cnt_q, cnt_nx;
    logic [PW-1:0]    pcnt_q, pcnt_nx;
    logic             to_q, to_nx;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_COUNT;
            cnt_q   <= '0;
            pcnt_q  <= '0;
            to_q    <= 1'b0;
        end else begin
            state_q <= state_nx;
            cnt_q   <= cnt_nx;
            pcnt_q  <= pcnt_nx;
            to_q    <= to_nx;
        end
    end

    always_comb begin
        state_nx = state_q;
        cnt_nx   = cnt_q;
        pcnt_nx  = pcnt_q;
        to_nx    = to_q;
        unique case (state_q)
            ST_COUNT: begin
                if (accept) begin
                    cnt_nx = '0;
                    to_nx  = 1'b0;
                end else if (tick) begin
                    if (cnt_q == CNT_TOP) begin
                        state_nx = ST_BITE;
                        cnt_nx   = '0;
                        pcnt_nx  = '0;
                        to_nx    = 1'b1;
                    end else begin
                        cnt_nx = cnt_q + CNT_W'(1);
                    end
                end
            end
            ST_BITE: begin
                cnt_nx = '0;
                if (pcnt_q == P_LAST) begin
                    state_nx = ST_COUNT;
                    pcnt_nx  = '0;
                end else begin
                    pcnt_nx = pcnt_q + PW'(1);
                end
            end
            default: state_nx = ST_COUNT;
        endcase
    end

    always_comb begin
        bite    = (state_q == ST_BITE);
        flush   = (state_q == ST_BITE);
        to_flag = to_q;
    end

endmodule

// File: rtl/guard_timer.sv
module guard_timer
    import guard_pkg::*;
#(
    parameter int CNT_W     = 4,
    parameter int PULSE_LEN = 4,
    parameter int SYS_DIV   = 4
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic [1:0] cfg_src,
    input  logic       cfg_dual,
    input  logic       halt,
    input  logic       rtc_tick,
    input  logic       osc_tick,
    input  logic       clr_one,
    input  logic       clr_a,
    input  logic       clr_b,
    output logic       bite_rst,
    output logic       timed_out
);
    logic sel_tick;
    logic accept;
    logic flush;

    guard_tick_sel #(.SYS_DIV(SYS_DIV)) u_tick (
        .clk      (clk),
        .rst_n    (rst_n),
        .cfg_src  (cfg_src),
        .halt     (halt),
        .rtc_tick (rtc_tick),
        .osc_tick (osc_tick),
        .tick     (sel_tick)
    );

    guard_clear_pair u_pair (
        .clk     (clk),
        .rst_n   (rst_n),
        .dual    (cfg_dual),
        .flush   (flush),
        .clr_one (clr_one),
        .clr_a   (clr_a),
        .clr_b   (clr_b),
        .accept  (accept)
    );

    guard_core #(.CNT_W(CNT_W), .PULSE_LEN(PULSE_LEN)) u_core (
        .clk     (clk),
        .rst_n   (rst_n),
        .tick    (sel_tick),
        .accept  (accept),
        .bite    (bite_rst),
        .to_flag (timed_out),
        .flush   (flush)
    );

endmodule

// File: rtl/guard_timer_chk.sv
module guard_timer_chk #(
    parameter int CNT_W     = 4,
    parameter int PULSE_LEN = 4
) (
    input logic       clk,
    input logic       rst_n,
    input logic [1:0] cfg_src,
    input logic       cfg_dual,
    input logic       halt,
    input logic       clr_one,
    input logic       clr_a,
    input logic       clr_b,
    input logic       bite_rst,
    input logic       timed_out,
    input logic       sel_tick
);
    localparam int HW = $clog2(PULSE_LEN + 2) + 1;
    logic [HW-1:0] hi_run;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            hi_run <= '0;
        end else if (bite_rst) begin
            hi_run <= hi_run + HW'(1);
        end else begin
            hi_run <= '0;
        end
    end

    a_r4_pulse_exact: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(bite_rst) |-> (hi_run == HW'(PULSE_LEN)));

    a_r4_pulse_bound: assert property (@(posedge clk) disable iff (!rst_n)
        hi_run <= HW'(PULSE_LEN));

    a_r5_flag_with_bite: assert property (@(posedge clk) disable iff (!rst_n)
        bite_rst |-> timed_out);

    a_r2_bite_needs_tick: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(bite_rst) |-> $past(sel_tick));

    a_r3_halt_freeze: assert property (@(posedge clk) disable iff (!rst_n)
        (halt && cfg_src == 2'd0 && !bite_rst) |=> !bite_rst);

    a_r7_single_clear: assert property (@(posedge clk) disable iff (!rst_n)
        (!cfg_dual && clr_one && !bite_rst) |=> !timed_out);

    a_r11_flag_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (timed_out && !clr_one && !clr_a && !clr_b) |=> timed_out);

endmodule

bind guard_timer guard_timer_chk #(.CNT_W(CNT_W), .PULSE_LEN(PULSE_LEN)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .cfg_src   (cfg_src),
    .cfg_dual  (cfg_dual),
    .halt      (halt),
    .clr_one   (clr_one),
    .clr_a     (clr_a),
    .clr_b     (clr_b),
    .bite_rst  (bite_rst),
    .timed_out (timed_out),
    .sel_tick  (sel_tick)
);

// File: tb/tb_guard_timer.sv
`timescale 1ns/1ps
module tb_guard_timer;
    localparam int CNT_W     = 4;
    localparam int PULSE_LEN = 4;
    localparam int SYS_DIV   = 4;
    localparam int TICKS     = 1 << CNT_W;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [1:0] cfg_src = 2'd1;
    logic       cfg_dual = 1'b0;
    logic       halt = 1'b0;
    logic       rtc_tick = 1'b0;
    logic       osc_tick = 1'b0;
    logic       clr_one = 1'b0;
    logic       clr_a = 1'b0;
    logic       clr_b = 1'b0;
    logic       bite_rst;
    logic       timed_out;

    int n_chk = 0;
    int n_err = 0;
    bit seen_bite = 1'b0;

    always #2 clk = ~clk;

    guard_timer #(.CNT_W(CNT_W), .PULSE_LEN(PULSE_LEN), .SYS_DIV(SYS_DIV)) dut (
        .clk(clk), .rst_n(rst_n), .cfg_src(cfg_src), .cfg_dual(cfg_dual),
        .halt(halt), .rtc_tick(rtc_tick), .osc_tick(osc_tick),
        .clr_one(clr_one), .clr_a(clr_a), .clr_b(clr_b),
        .bite_rst(bite_rst), .timed_out(timed_out)
    );

    always @(negedge clk) if (bite_rst) seen_bite = 1'b1;

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic por(input logic [1:0] src, input bit dual, input bit hlt);
        @(negedge clk);
        rst_n = 1'b0; cfg_src = src; cfg_dual = dual; halt = hlt;
        rtc_tick = 0; osc_tick = 0; clr_one = 0; clr_a = 0; clr_b = 0;
        repeat (2) @(negedge clk);
        check(!bite_rst && !timed_out, "R6 reset state", {bite_rst, timed_out}, 0);
        seen_bite = 1'b0;
        rst_n = 1'b1;
    endtask

    task automatic feed(input bit on);
        rtc_tick = on && (cfg_src == 2'd1);
        osc_tick = on && (cfg_src >= 2'd2);
    endtask

    task automatic give_ticks(input int n);
        rtc_tick = 1'b1;
        repeat (n) @(negedge clk);
        rtc_tick = 1'b0;
    endtask

    task automatic strobe(input bit one, input bit a, input bit b);
        clr_one = one; clr_a = a; clr_b = b;
        @(negedge clk);
        clr_one = 0; clr_a = 0; clr_b = 0;
    endtask

    task automatic measure(input int limit, output int k);
        k = 0;
        while (k < limit) begin
            @(negedge clk);
            k++;
            if (bite_rst) break;
        end
        if (!bite_rst) k = -1;
    endtask

    task automatic pulse_width(output int w);
        w = 0;
        while (bite_rst && w < 100) begin
            @(negedge clk);
            w++;
        end
    endtask

    initial begin
        #600000;
        n_err++;
        $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    end

    initial begin
        int k;
        int w;
        // configuration sweep: R1 R2 R3 R4 R5
        for (int s = 0; s < 3; s++) begin
            for (int d = 0; d < 2; d++) begin
                for (int h = 0; h < 2; h++) begin
                    int period;
                    period = ((s == 0) ? SYS_DIV : 1) * TICKS;
                    por(2'(s), d[0], h[0]);
                    feed(1'b1);
                    if (s == 0 && h == 1) begin
                        repeat (300) @(negedge clk);
                        check(!seen_bite && !timed_out, "R3 halt freezes divided source",
                              seen_bite, 0);
                    end else begin
                        measure(period + 20, k);
                        check(k == period, "R1 R2 R3 time to timeout", k, period);
                        check(timed_out == 1'b1, "R5 flag set at timeout", timed_out, 1);
                        pulse_width(w);
                        check(w == PULSE_LEN, "R4 pulse width", w, PULSE_LEN);
                        check(timed_out == 1'b1, "R5 flag kept after pulse", timed_out, 1);
                        measure(period + 20, k);
                        check(k == period, "R4 restart from zero", k, period);
                        pulse_width(w);
                    end
                    feed(1'b0);
                end
            end
        end

        // R1 unselected source ignored, code 3 maps to the watchdog oscillator
        por(2'd3, 1'b0, 1'b0);
        give_ticks(40);
        check(!seen_bite, "R1 unselected rtc ignored", seen_bite, 0);
        feed(1'b1);
        measure(40, k);
        check(k == TICKS, "R1 code 3 uses osc", k, TICKS);
        feed(1'b0);

        // R7 single clear, and the pair strobes ignored
        por(2'd1, 1'b0, 1'b0);
        give_ticks(10);
        strobe(1'b1, 1'b0, 1'b0);
        feed(1'b1); measure(40, k); feed(1'b0);
        check(k == TICKS, "R7 single clear restarts", k, TICKS);
        por(2'd1, 1'b0, 1'b0);
        give_ticks(10);
        strobe(1'b0, 1'b1, 1'b0);
        strobe(1'b0, 1'b0, 1'b1);
        feed(1'b1); measure(40, k); feed(1'b0);
        check(k == TICKS - 10, "R7 pair strobes ignored in single mode", k, TICKS - 10);

        // R10 clear beats tick in same cycle at terminal count
        por(2'd1, 1'b0, 1'b0);
        give_ticks(TICKS - 1);
        rtc_tick = 1'b1;
        strobe(1'b1, 1'b0, 1'b0);
        rtc_tick = 1'b0;
        check(!bite_rst, "R10 no bite on clear+tick", bite_rst, 0);
        feed(1'b1); measure(40, k); feed(1'b0);
        check(k == TICKS, "R10 count zero after clear+tick", k, TICKS);

        // R8 dual: order a then b, b then a, simultaneous; single ignored
        por(2'd1, 1'b1, 1'b0);
        give_ticks(10);
        strobe(1'b0, 1'b1, 1'b0);
        give_ticks(5);
        feed(1'b1); measure(40, k); feed(1'b0);
        check(k == 1, "R8 half pair does not clear", k, 1);
        pulse_width(w);

        por(2'd1, 1'b1, 1'b0);
        give_ticks(10);
        strobe(1'b0, 1'b0, 1'b1);
        give_ticks(3);
        strobe(1'b0, 1'b1, 1'b0);
        feed(1'b1); measure(40, k); feed(1'b0);
        check(k == TICKS, "R8 order b then a clears", k, TICKS);

        por(2'd1, 1'b1, 1'b0);
        give_ticks(10);
        strobe(1'b0, 1'b1, 1'b1);
        feed(1'b1); measure(40, k); feed(1'b0);
        check(k == TICKS, "R8 simultaneous pair clears", k, TICKS);

        por(2'd1, 1'b1, 1'b0);
        give_ticks(10);
        strobe(1'b1, 1'b0, 1'b0);
        feed(1'b1); measure(40, k); feed(1'b0);
        check(k == TICKS - 10, "R8 single strobe ignored in dual", k, TICKS - 10);

        // R9 pending forgotten after pair; repeated a is not a pair
        por(2'd1, 1'b1, 1'b0);
        give_ticks(4);
        strobe(1'b0, 1'b1, 1'b0);
        strobe(1'b0, 1'b0, 1'b1);
        strobe(1'b0, 1'b1, 1'b0);
        give_ticks(10);
        strobe(1'b0, 1'b1, 1'b0);
        feed(1'b1); measure(40, k); feed(1'b0);
        check(k == TICKS - 10, "R9 repeated a after pair", k, TICKS - 10);

        // R11 flag cleared by accepted clear only
        pulse_width(w);
        check(timed_out == 1'b1, "R11 flag set before clear", timed_out, 1);
        strobe(1'b0, 1'b1, 1'b0);
        check(timed_out == 1'b1, "R11 half pair keeps flag", timed_out, 1);
        strobe(1'b0, 1'b0, 1'b1);
        check(timed_out == 1'b0, "R11 pair clears flag", timed_out, 0);

        por(2'd1, 1'b0, 1'b0);
        feed(1'b1); measure(40, k); feed(1'b0);
        pulse_width(w);
        strobe(1'b1, 1'b0, 1'b0);
        check(timed_out == 1'b0, "R11 single clear drops flag", timed_out, 0);

        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    end

endmodule